// File: doc/BRIEF.md
# Coprocessor Mailbox and Run-Control Register Slave

This block is the host-visible register window of a coprocessor. A host reaches it over a simple 32-bit register bus. The bus has valid, write, word address and write data, and read data and an error flag come back in the same cycle. Behind the window sit two mailbox FIFOs: an inbound one that the host fills and the core drains, and an outbound one that the core fills and the host drains. A packed status word reports how full each mailbox is.

The same window controls the core. A run-control register starts and stops it, and a status register reports whether it is running or stopped. A next-program-counter register supplies the start address, and the core writes it back when it halts. Two signal-notification registers are also held here.

A small DMA command set is the last part of the window. It holds a local-store address, an effective address split into high and low words, a size/tag word, a queue-status word, a proxy query type, a query mask and a tag status. A write to the command word emits a one-cycle enqueue pulse toward an external DMA engine. A write to the query type loads the queue status from the query mask. The DMA engine, the core and the local store are outside the block; only their handshake pins appear.

Top module: `mbox_runctl_regs`

## Requirements
- R1: A read of word offset 0x0B returns the outbound mailbox entry count in bits 7:0, the inbound mailbox free-slot count in bits 15:8, and zero in bits 31:16; after reset it reads 0x0000_0400.
- R2: Host writes to offset 0x0A enter the inbound mailbox (depth 4). The core drains it in arrival order through a valid/ready handshake, where in_mb_valid_o is high whenever the mailbox holds an entry.
- R3: A host write to offset 0x0A while the inbound mailbox is full and not being popped in the same cycle replaces the newest entry and leaves the count at 4.
- R4: The core pushes the outbound mailbox (depth 1) through a valid/ready handshake, with out_mb_ready_o low while it is full. A host read of offset 0x09 returns and removes the oldest entry. A read while it is empty leaves the count at 0.
- R5: Writing 1 to run control (0x0C) sets core status (0x0D) to RUNNING (1) and pulses core_start_o in the next cycle. Writing 0 sets it to STOPPED (2) and pulses core_stop_o. Run control reads 1 while running and 0 otherwise. Status resets to STOPPED.
- R6: Writing any other value to run control raises bus_err_o in the access cycle, leaves the status unchanged and produces no start or stop pulse.
- R7: Writing the DMA command word (0x04) stores it and, in the next cycle, pulses dma_enq_o. During that pulse dma_cmd_o carries the written value and dma_lsa_o (0x00), dma_eah_o (0x01), dma_eal_o (0x02) and dma_size_tag_o (0x03) carry the stored registers.
- R8: Writing the proxy query type (0x06) leaves it reading 0. The same write copies the query mask (0x07) into the queue status (0x05).
- R9: An access to an offset above 0x10 raises bus_err_o in the access cycle and reads zero.
- R10: The next-PC register (0x0E) takes host writes only while the core is stopped and drives core_npc_o. A core_halted_i pulse while running loads it from core_pc_i and sets the status to STOPPED.
- R11: A host write to the full inbound mailbox in the same cycle as a core pop is an ordinary push: no entry is replaced and the count stays 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| bus_err_o | output | 1 | Unmapped access or illegal run-control value |
| in_mb_valid_o | output | 1 | Inbound mailbox not empty |
| in_mb_data_o | output | 32 | Inbound mailbox head |
| in_mb_ready_i | input | 1 | Core pops inbound mailbox |
| out_mb_valid_i | input | 1 | Core offers an outbound word |
| out_mb_data_i | input | 32 | Outbound word |
| out_mb_ready_o | output | 1 | Outbound mailbox can accept |
| core_start_o | output | 1 | One-cycle start pulse |
| core_stop_o | output | 1 | One-cycle stop pulse |
| core_npc_o | output | 32 | Next program counter |
| core_halted_i | input | 1 | Core reports it has halted |
| core_pc_i | input | 32 | Program counter at halt |
| dma_enq_o | output | 1 | One-cycle DMA enqueue pulse |
| dma_cmd_o | output | 32 | Command word |
| dma_lsa_o | output | 32 | Local-store address |
| dma_eah_o | output | 32 | Effective address, high word |
| dma_eal_o | output | 32 | Effective address, low word |
| dma_size_tag_o | output | 32 | Size and tag word |

## Verification
The interaction that matters is a host write to the full inbound mailbox in the same cycle as a core pop. The write must then be treated as a normal append and not as an overwrite of the newest entry. A second case of the same kind is a host read of the outbound mailbox in the same cycle as a core push attempt. A randomized phase draws host operations, core pops and core pushes independently in every cycle, so both collisions happen many times. A queue model in the bench applies the pop before the push and compares every head value, handshake signal and status word against the design.

// File: rtl/mbox_rc_pkg.sv
package mbox_rc_pkg;
    localparam int MRC_ADDR_W = 5;
    localparam int MRC_DATA_W = 32;

    localparam logic [MRC_ADDR_W-1:0] OFS_DMA_LSA   = 5'h00;
    localparam logic [MRC_ADDR_W-1:0] OFS_DMA_EAH   = 5'h01;
    localparam logic [MRC_ADDR_W-1:0] OFS_DMA_EAL   = 5'h02;
    localparam logic [MRC_ADDR_W-1:0] OFS_DMA_SZTAG = 5'h03;
    localparam logic [MRC_ADDR_W-1:0] OFS_DMA_CMD   = 5'h04;
    localparam logic [MRC_ADDR_W-1:0] OFS_QSTAT     = 5'h05;
    localparam logic [MRC_ADDR_W-1:0] OFS_QTYPE     = 5'h06;
    localparam logic [MRC_ADDR_W-1:0] OFS_QMASK     = 5'h07;
    localparam logic [MRC_ADDR_W-1:0] OFS_TAGSTAT   = 5'h08;
    localparam logic [MRC_ADDR_W-1:0] OFS_OUT_MB    = 5'h09;
    localparam logic [MRC_ADDR_W-1:0] OFS_IN_MB     = 5'h0A;
    localparam logic [MRC_ADDR_W-1:0] OFS_MB_STAT   = 5'h0B;
    localparam logic [MRC_ADDR_W-1:0] OFS_RUNCTL    = 5'h0C;
    localparam logic [MRC_ADDR_W-1:0] OFS_CSTAT     = 5'h0D;
    localparam logic [MRC_ADDR_W-1:0] OFS_NPC       = 5'h0E;
    localparam logic [MRC_ADDR_W-1:0] OFS_SIG0      = 5'h0F;
    localparam logic [MRC_ADDR_W-1:0] OFS_SIG1      = 5'h10;
    localparam logic [MRC_ADDR_W-1:0] OFS_LAST      = OFS_SIG1;

    localparam logic [MRC_DATA_W-1:0] RUN_CODE_GO   = 32'd1;
    localparam logic [MRC_DATA_W-1:0] RUN_CODE_HALT = 32'd0;
    localparam logic [MRC_DATA_W-1:0] CST_RUNNING   = 32'd1;
    localparam logic [MRC_DATA_W-1:0] CST_STOPPED   = 32'd2;

    localparam int SIG_REGS = 2;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
    parameter int DEPTH     = 4,
    parameter int W         = 32,
    parameter bit OVERWRITE = 1'b0,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic [W-1:0]     data_i,
    input  logic             pop_i,
    output logic [W-1:0]     head_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rd;
        logic [PTR_W-1:0]        wr;
        logic [CNT_W-1:0]        cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] ptr_prev(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_LAST : p - PTR_W'(1);
    endfunction

    logic full, empty, do_pop, do_push;

    always_comb begin
        st_d    = st_q;
        full    = (st_q.cnt == CNT_W'(DEPTH));
        empty   = (st_q.cnt == '0);
        do_pop  = pop_i && !empty;
        do_push = push_i && (!full || do_pop);

        if (do_pop) begin
            st_d.rd = ptr_next(st_q.rd);
        end
        if (do_push) begin
            st_d.mem[st_q.wr] = data_i;
            st_d.wr           = ptr_next(st_q.wr);
        end else if (push_i && OVERWRITE) begin
            st_d.mem[ptr_prev(st_q.wr)] = data_i;
        end

        st_d.cnt = st_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o  = st_q.mem[st_q.rd];
    assign count_o = st_q.cnt;
endmodule

// File: rtl/runctl_unit.sv
module runctl_unit
    import mbox_rc_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  run_wr_i,
    input  logic                  npc_wr_i,
    input  logic [MRC_DATA_W-1:0] wdata_i,
    input  logic                  halted_i,
    input  logic [MRC_DATA_W-1:0] halt_pc_i,
    output logic [MRC_DATA_W-1:0] status_o,
    output logic                  running_o,
    output logic [MRC_DATA_W-1:0] npc_o,
    output logic                  start_o,
    output logic                  stop_o,
    output logic                  illegal_o
);
    typedef struct packed {
        logic [MRC_DATA_W-1:0] status;
        logic [MRC_DATA_W-1:0] npc;
        logic                  start;
        logic                  stop;
    } rc_state_t;

    rc_state_t st_d, st_q;
    logic running, go_cmd, halt_cmd;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.stop  = 1'b0;
        running    = (st_q.status == CST_RUNNING);
        go_cmd     = run_wr_i && (wdata_i == RUN_CODE_GO);
        halt_cmd   = run_wr_i && (wdata_i == RUN_CODE_HALT);
        illegal_o  = run_wr_i && !go_cmd && !halt_cmd;

        if (go_cmd) begin
            st_d.status = CST_RUNNING;
            st_d.start  = 1'b1;
        end else if (halt_cmd) begin
            st_d.status = CST_STOPPED;
            st_d.stop   = 1'b1;
        end else if (halted_i && running) begin
            st_d.status = CST_STOPPED;
        end

        if (halted_i && running) begin
            st_d.npc = halt_pc_i;
        end else if (npc_wr_i && !running) begin
            st_d.npc = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q        <= '0;
            st_q.status <= CST_STOPPED;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o  = st_q.status;
    assign running_o = (st_q.status == CST_RUNNING);
    assign npc_o     = st_q.npc;
    assign start_o   = st_q.start;
    assign stop_o    = st_q.stop;
endmodule

// File: rtl/dma_cmd_regs.sv
module dma_cmd_regs
    import mbox_rc_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_i,
    input  logic [MRC_ADDR_W-1:0] addr_i,
    input  logic [MRC_DATA_W-1:0] wdata_i,
    output logic [MRC_DATA_W-1:0] rdata_o,
    output logic                  enq_o,
    output logic [MRC_DATA_W-1:0] cmd_o,
    output logic [MRC_DATA_W-1:0] lsa_o,
    output logic [MRC_DATA_W-1:0] eah_o,
    output logic [MRC_DATA_W-1:0] eal_o,
    output logic [MRC_DATA_W-1:0] size_tag_o
);
    typedef struct packed {
        logic [MRC_DATA_W-1:0] lsa;
        logic [MRC_DATA_W-1:0] eah;
        logic [MRC_DATA_W-1:0] eal;
        logic [MRC_DATA_W-1:0] size_tag;
        logic [MRC_DATA_W-1:0] cmd;
        logic [MRC_DATA_W-1:0] qstat;
        logic [MRC_DATA_W-1:0] qtype;
        logic [MRC_DATA_W-1:0] qmask;
        logic [MRC_DATA_W-1:0] tagstat;
        logic                  enq;
    } dma_state_t;

    dma_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.enq = 1'b0;
        if (wr_i) begin
            unique case (addr_i)
                OFS_DMA_LSA:   st_d.lsa      = wdata_i;
                OFS_DMA_EAH:   st_d.eah      = wdata_i;
                OFS_DMA_EAL:   st_d.eal      = wdata_i;
                OFS_DMA_SZTAG: st_d.size_tag = wdata_i;
                OFS_DMA_CMD: begin
                    st_d.cmd = wdata_i;
                    st_d.enq = 1'b1;
                end
                OFS_QSTAT:     st_d.qstat    = wdata_i;
                OFS_QTYPE: begin
                    st_d.qtype = '0;
                    st_d.qstat = st_q.qmask;
                end
                OFS_QMASK:     st_d.qmask    = wdata_i;
                OFS_TAGSTAT:   st_d.tagstat  = wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr_i)
            OFS_DMA_LSA:   rdata_o = st_q.lsa;
            OFS_DMA_EAH:   rdata_o = st_q.eah;
            OFS_DMA_EAL:   rdata_o = st_q.eal;
            OFS_DMA_SZTAG: rdata_o = st_q.size_tag;
            OFS_DMA_CMD:   rdata_o = st_q.cmd;
            OFS_QSTAT:     rdata_o = st_q.qstat;
            OFS_QTYPE:     rdata_o = st_q.qtype;
            OFS_QMASK:     rdata_o = st_q.qmask;
            OFS_TAGSTAT:   rdata_o = st_q.tagstat;
            default:       rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enq_o      = st_q.enq;
    assign cmd_o      = st_q.cmd;
    assign lsa_o      = st_q.lsa;
    assign eah_o      = st_q.eah;
    assign eal_o      = st_q.eal;
    assign size_tag_o = st_q.size_tag;
endmodule

// File: rtl/mbox_runctl_regs.sv
module mbox_runctl_regs
    import mbox_rc_pkg::*;
#(
    parameter int IN_DEPTH  = 4,
    parameter int OUT_DEPTH = 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  bus_valid_i,
    input  logic                  bus_write_i,
    input  logic [MRC_ADDR_W-1:0] bus_addr_i,
    input  logic [MRC_DATA_W-1:0] bus_wdata_i,
    output logic [MRC_DATA_W-1:0] bus_rdata_o,
    output logic                  bus_err_o,
    output logic                  in_mb_valid_o,
    output logic [MRC_DATA_W-1:0] in_mb_data_o,
    input  logic                  in_mb_ready_i,
    input  logic                  out_mb_valid_i,
    input  logic [MRC_DATA_W-1:0] out_mb_data_i,
    output logic                  out_mb_ready_o,
    output logic                  core_start_o,
    output logic                  core_stop_o,
    output logic [MRC_DATA_W-1:0] core_npc_o,
    input  logic                  core_halted_i,
    input  logic [MRC_DATA_W-1:0] core_pc_i,
    output logic                  dma_enq_o,
    output logic [MRC_DATA_W-1:0] dma_cmd_o,
    output logic [MRC_DATA_W-1:0] dma_lsa_o,
    output logic [MRC_DATA_W-1:0] dma_eah_o,
    output logic [MRC_DATA_W-1:0] dma_eal_o,
    output logic [MRC_DATA_W-1:0] dma_size_tag_o
);
    localparam int IN_CNT_W  = $clog2(IN_DEPTH + 1);
    localparam int OUT_CNT_W = $clog2(OUT_DEPTH + 1);
    localparam int STAT_W    = 8;

    typedef struct packed {
        logic [SIG_REGS-1:0][MRC_DATA_W-1:0] sig;
    } top_state_t;

    top_state_t st_d, st_q;

    logic wr_acc, rd_acc, mapped;
    logic in_push, out_pop;
    logic [IN_CNT_W-1:0]   in_cnt;
    logic [OUT_CNT_W-1:0]  out_cnt;
    logic [MRC_DATA_W-1:0] out_head, dma_rdata, cstat;
    logic [STAT_W-1:0]     in_free, out_used;
    logic running, run_illegal;

    assign wr_acc  = bus_valid_i && bus_write_i;
    assign rd_acc  = bus_valid_i && !bus_write_i;
    assign mapped  = (bus_addr_i <= OFS_LAST);
    assign in_push = wr_acc && (bus_addr_i == OFS_IN_MB);
    assign out_pop = rd_acc && (bus_addr_i == OFS_OUT_MB);

    mbox_fifo #(
        .DEPTH     (IN_DEPTH),
        .W         (MRC_DATA_W),
        .OVERWRITE (1'b1)
    ) i_in_mbox (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (in_push),
        .data_i  (bus_wdata_i),
        .pop_i   (in_mb_ready_i),
        .head_o  (in_mb_data_o),
        .count_o (in_cnt)
    );

    mbox_fifo #(
        .DEPTH     (OUT_DEPTH),
        .W         (MRC_DATA_W),
        .OVERWRITE (1'b0)
    ) i_out_mbox (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (out_mb_valid_i && out_mb_ready_o),
        .data_i  (out_mb_data_i),
        .pop_i   (out_pop),
        .head_o  (out_head),
        .count_o (out_cnt)
    );

    assign in_mb_valid_o  = (in_cnt != '0);
    assign out_mb_ready_o = (out_cnt != OUT_CNT_W'(OUT_DEPTH));
    assign in_free        = STAT_W'(IN_DEPTH) - STAT_W'(in_cnt);
    assign out_used       = STAT_W'(out_cnt);

    runctl_unit i_runctl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_wr_i  (wr_acc && (bus_addr_i == OFS_RUNCTL)),
        .npc_wr_i  (wr_acc && (bus_addr_i == OFS_NPC)),
        .wdata_i   (bus_wdata_i),
        .halted_i  (core_halted_i),
        .halt_pc_i (core_pc_i),
        .status_o  (cstat),
        .running_o (running),
        .npc_o     (core_npc_o),
        .start_o   (core_start_o),
        .stop_o    (core_stop_o),
        .illegal_o (run_illegal)
    );

    dma_cmd_regs i_dma (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (wr_acc),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .rdata_o    (dma_rdata),
        .enq_o      (dma_enq_o),
        .cmd_o      (dma_cmd_o),
        .lsa_o      (dma_lsa_o),
        .eah_o      (dma_eah_o),
        .eal_o      (dma_eal_o),
        .size_tag_o (dma_size_tag_o)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < SIG_REGS; i++) begin
            if (wr_acc && (bus_addr_i == OFS_SIG0 + MRC_ADDR_W'(i))) begin
                st_d.sig[i] = bus_wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (rd_acc) begin
            if (bus_addr_i <= OFS_TAGSTAT) begin
                bus_rdata_o = dma_rdata;
            end else begin
                unique case (bus_addr_i)
                    OFS_OUT_MB:  bus_rdata_o = out_head;
                    OFS_MB_STAT: bus_rdata_o = {16'h0, in_free, out_used};
                    OFS_RUNCTL:  bus_rdata_o = {31'h0, running};
                    OFS_CSTAT:   bus_rdata_o = cstat;
                    OFS_NPC:     bus_rdata_o = core_npc_o;
                    OFS_SIG0:    bus_rdata_o = st_q.sig[0];
                    OFS_SIG1:    bus_rdata_o = st_q.sig[1];
                    default:     bus_rdata_o = '0;
                endcase
            end
        end
    end

    assign bus_err_o = bus_valid_i && (!mapped || run_illegal);
endmodule

// File: rtl/mbox_rc_chk.sv
module mbox_rc_chk
    import mbox_rc_pkg::*;
(
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  bus_valid_i,
    input logic                  bus_write_i,
    input logic [MRC_ADDR_W-1:0] bus_addr_i,
    input logic [MRC_DATA_W-1:0] bus_wdata_i,
    input logic [MRC_DATA_W-1:0] bus_rdata_o,
    input logic                  bus_err_o,
    input logic                  in_mb_valid_o,
    input logic                  out_mb_ready_o,
    input logic                  core_start_o,
    input logic                  core_stop_o,
    input logic                  dma_enq_o,
    input logic [MRC_DATA_W-1:0] dma_cmd_o
);
    // R2
    in_push_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_valid_i && bus_write_i && bus_addr_i == OFS_IN_MB) |=> in_mb_valid_o);

    // R4
    out_full_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!out_mb_ready_o && !(bus_valid_i && !bus_write_i && bus_addr_i == OFS_OUT_MB))
        |=> !out_mb_ready_o);

    // R5
    start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_valid_i && bus_write_i && bus_addr_i == OFS_RUNCTL && bus_wdata_i == RUN_CODE_GO)
        |=> (core_start_o && !core_stop_o));

    // R5
    start_stop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(core_start_o && core_stop_o));

    // R6
    illegal_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_valid_i && bus_write_i && bus_addr_i == OFS_RUNCTL && bus_wdata_i > RUN_CODE_GO)
        |-> bus_err_o ##1 (!core_start_o && !core_stop_o));

    // R7
    enq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_valid_i && bus_write_i && bus_addr_i == OFS_DMA_CMD)
        |=> (dma_enq_o && dma_cmd_o == $past(bus_wdata_i)));

    // R9
    unmapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_valid_i && bus_addr_i > OFS_LAST) |-> (bus_err_o && bus_rdata_o == '0));
endmodule

bind mbox_runctl_regs mbox_rc_chk i_mbox_rc_chk (.*);

// File: tb/test_mbox_runctl_regs.sv
module test_mbox_runctl_regs;
    import mbox_rc_pkg::*;

    localparam int IN_D = 4;

    logic        clk = 1'b0;
    logic        rst_ni;
    logic        bus_valid, bus_write;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata_o;
    logic        bus_err_o;
    logic        in_mb_valid_o, in_mb_ready_i;
    logic [31:0] in_mb_data_o;
    logic        out_mb_valid_i, out_mb_ready_o;
    logic [31:0] out_mb_data_i;
    logic        core_start_o, core_stop_o, core_halted_i;
    logic [31:0] core_npc_o, core_pc_i;
    logic        dma_enq_o;
    logic [31:0] dma_cmd_o, dma_lsa_o, dma_eah_o, dma_eal_o, dma_size_tag_o;

    always #2 clk = ~clk;

    mbox_runctl_regs i_mbox_runctl_regs (
        .clk_i(clk), .rst_ni(rst_ni),
        .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata_o), .bus_err_o(bus_err_o),
        .in_mb_valid_o(in_mb_valid_o), .in_mb_data_o(in_mb_data_o), .in_mb_ready_i(in_mb_ready_i),
        .out_mb_valid_i(out_mb_valid_i), .out_mb_data_i(out_mb_data_i), .out_mb_ready_o(out_mb_ready_o),
        .core_start_o(core_start_o), .core_stop_o(core_stop_o), .core_npc_o(core_npc_o),
        .core_halted_i(core_halted_i), .core_pc_i(core_pc_i),
        .dma_enq_o(dma_enq_o), .dma_cmd_o(dma_cmd_o), .dma_lsa_o(dma_lsa_o),
        .dma_eah_o(dma_eah_o), .dma_eal_o(dma_eal_o), .dma_size_tag_o(dma_size_tag_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] last_rd;
    logic        last_err;
    logic [31:0] inq[$];
    logic [31:0] outq[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mb_stat(input int oc, input int ic);
        return {16'h0, 8'(IN_D - ic), 8'(oc)};
    endfunction

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        #1 last_err = bus_err_o;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 last_rd = bus_rdata_o; last_err = bus_err_o;
        @(posedge clk); @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_ni = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", checks, -1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
        in_mb_ready_i = 0; out_mb_valid_i = 0; out_mb_data_i = '0;
        core_halted_i = 0; core_pc_i = '0;
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();

        // reset state
        bus_rd(OFS_MB_STAT); chk("R1 reset mbox status", last_rd, 32'h0000_0400);
        bus_rd(OFS_CSTAT);   chk("R5 reset status", last_rd, CST_STOPPED);
        bus_rd(OFS_RUNCTL);  chk("R5 reset runctl", last_rd, 32'h0);
        chk("R4 reset out ready", 32'(out_mb_ready_o), 32'h1);

        // R3 overwrite of newest when full
        bus_wr(OFS_IN_MB, 32'hA1); bus_wr(OFS_IN_MB, 32'hB2);
        bus_wr(OFS_IN_MB, 32'hC3); bus_wr(OFS_IN_MB, 32'hD4);
        bus_rd(OFS_MB_STAT); chk("R1 inbound full status", last_rd, 32'h0000_0000);
        bus_wr(OFS_IN_MB, 32'hE5);
        chk("R3 write to full no error", 32'(last_err), 32'h0);
        bus_rd(OFS_MB_STAT); chk("R3 count stays 4", last_rd, 32'h0000_0000);
        foreach (inq[i]) ; // keep queue untouched
        begin
            logic [31:0] exp_seq [4];
            exp_seq = '{32'hA1, 32'hB2, 32'hC3, 32'hE5};
            for (int k = 0; k < 4; k++) begin
                in_mb_ready_i = 1'b1;
                #1 chk("R2 R3 inbound order", in_mb_data_o, exp_seq[k]);
                @(posedge clk); @(negedge clk);
            end
            in_mb_ready_i = 1'b0;
        end
        chk("R2 inbound empty valid low", 32'(in_mb_valid_o), 32'h0);

        // R4 outbound
        bus_rd(OFS_OUT_MB);
        bus_rd(OFS_MB_STAT); chk("R4 empty pop keeps zero", last_rd, 32'h0000_0400);
        out_mb_valid_i = 1'b1; out_mb_data_i = 32'h5555_0001;
        @(posedge clk); @(negedge clk);
        out_mb_data_i = 32'h5555_0002;
        #1 chk("R4 ready low when full", 32'(out_mb_ready_o), 32'h0);
        @(posedge clk); @(negedge clk);
        out_mb_valid_i = 1'b0;
        bus_rd(OFS_MB_STAT); chk("R1 outbound count", last_rd, 32'h0000_0401);
        bus_rd(OFS_OUT_MB);  chk("R4 outbound data held off", last_rd, 32'h5555_0001);
        bus_rd(OFS_MB_STAT); chk("R4 outbound popped", last_rd, 32'h0000_0400);

        // R5 / R6 / R10 run control
        bus_wr(OFS_NPC, 32'h100);
        bus_wr(OFS_RUNCTL, RUN_CODE_GO);
        chk("R5 start pulse", 32'(core_start_o), 32'h1);
        chk("R10 npc presented", core_npc_o, 32'h100);
        bus_rd(OFS_CSTAT);  chk("R5 status running", last_rd, CST_RUNNING);
        bus_rd(OFS_RUNCTL); chk("R5 runctl reads 1", last_rd, 32'h1);
        bus_wr(OFS_NPC, 32'h200);
        bus_rd(OFS_NPC);    chk("R10 npc write ignored while running", last_rd, 32'h100);
        bus_wr(OFS_RUNCTL, 32'h7);
        chk("R6 illegal error", 32'(last_err), 32'h1);
        chk("R6 no pulse", 32'({core_start_o, core_stop_o}), 32'h0);
        bus_rd(OFS_CSTAT);  chk("R6 status unchanged", last_rd, CST_RUNNING);
        core_halted_i = 1'b1; core_pc_i = 32'h180;
        @(posedge clk); @(negedge clk);
        core_halted_i = 1'b0;
        bus_rd(OFS_CSTAT);  chk("R10 halt stops", last_rd, CST_STOPPED);
        bus_rd(OFS_NPC);    chk("R10 halt pc written back", last_rd, 32'h180);
        bus_wr(OFS_RUNCTL, RUN_CODE_GO);
        bus_wr(OFS_RUNCTL, RUN_CODE_HALT);
        chk("R5 stop pulse", 32'(core_stop_o), 32'h1);
        bus_rd(OFS_CSTAT);  chk("R5 status stopped", last_rd, CST_STOPPED);
        bus_rd(OFS_RUNCTL); chk("R5 runctl reads 0", last_rd, 32'h0);
        bus_wr(OFS_NPC, 32'h240);
        bus_rd(OFS_NPC);    chk("R10 npc write while stopped", last_rd, 32'h240);

        // R7 DMA enqueue
        bus_wr(OFS_DMA_LSA, 32'h0000_3000);
        bus_wr(OFS_DMA_EAH, 32'h0000_0001);
        bus_wr(OFS_DMA_EAL, 32'h8000_0040);
        bus_wr(OFS_DMA_SZTAG, 32'h0080_0005);
        chk("R7 no enq before cmd", 32'(dma_enq_o), 32'h0);
        bus_wr(OFS_DMA_CMD, 32'h0000_0040);
        chk("R7 enq pulse", 32'(dma_enq_o), 32'h1);
        chk("R7 cmd", dma_cmd_o, 32'h0000_0040);
        chk("R7 lsa", dma_lsa_o, 32'h0000_3000);
        chk("R7 eah", dma_eah_o, 32'h0000_0001);
        chk("R7 eal", dma_eal_o, 32'h8000_0040);
        chk("R7 size tag", dma_size_tag_o, 32'h0080_0005);
        @(posedge clk); #1 chk("R7 pulse one cycle", 32'(dma_enq_o), 32'h0);
        @(negedge clk);

        // R8 proxy query
        bus_wr(OFS_QMASK, 32'h0000_005A);
        bus_wr(OFS_QTYPE, 32'h2);
        bus_rd(OFS_QTYPE); chk("R8 query type self-clears", last_rd, 32'h0);
        bus_rd(OFS_QSTAT); chk("R8 qstatus loaded", last_rd, 32'h0000_005A);

        // R9 unmapped
        bus_rd(5'h1F);
        chk("R9 unmapped read zero", last_rd, 32'h0);
        chk("R9 unmapped read error", 32'(last_err), 32'h1);
        bus_wr(5'h15, 32'hFFFF_FFFF);
        chk("R9 unmapped write error", 32'(last_err), 32'h1);
        bus_rd(OFS_SIG1); chk("R9 mapped no error", 32'(last_err), 32'h0);

        // random phase: concurrent host and core mailbox traffic (R1 R2 R3 R4 R11)
        do_reset();
        inq.delete(); outq.delete();
        for (int n = 0; n < 600; n++) begin
            int op;
            bit pop_req, push_req;
            logic [31:0] wd, pd;
            int oc;
            op = int'($urandom % 4);
            pop_req = ($urandom % 3) == 0;
            push_req = ($urandom % 2) == 0;
            wd = $urandom; pd = $urandom;
            in_mb_ready_i = pop_req; out_mb_valid_i = push_req; out_mb_data_i = pd;
            bus_valid = (op != 3); bus_write = (op == 0); bus_wdata = wd;
            bus_addr = (op == 0) ? OFS_IN_MB : (op == 1) ? OFS_OUT_MB : OFS_MB_STAT;
            #1;
            chk("R2 inbound valid", 32'(in_mb_valid_o), 32'(inq.size() != 0));
            if (pop_req && inq.size() != 0) chk("R2 inbound head", in_mb_data_o, inq[0]);
            chk("R4 outbound ready", 32'(out_mb_ready_o), 32'(outq.size() == 0));
            if (op == 2) chk("R1 status word", bus_rdata_o, mb_stat(outq.size(), inq.size()));
            if (op == 1 && outq.size() != 0) chk("R4 outbound head", bus_rdata_o, outq[0]);
            if (pop_req && inq.size() != 0) void'(inq.pop_front());
            if (op == 0) begin
                if (inq.size() == IN_D) inq[IN_D-1] = wd;   // R3; R11 when popped above
                else inq.push_back(wd);
            end
            oc = outq.size();
            if (op == 1 && oc != 0) void'(outq.pop_front());
            if (push_req && oc == 0) outq.push_back(pd);
            @(negedge clk);
        end
        bus_valid = 0; bus_write = 0; in_mb_ready_i = 0; out_mb_valid_i = 0;
        bus_rd(OFS_MB_STAT); chk("R1 final status", last_rd, mb_stat(outq.size(), inq.size()));

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule